// File: doc/BRIEF.md
# Receive Line Idle Detector

This block watches an asynchronous serial receive line and raises a single flag once the line has gone quiet. What counts as quiet depends on the link discipline. In the bit-oriented, HDLC-style discipline the line is quiet after an unbroken run of fifteen one bits. In the carrier-sense (CSMA/CD) discipline it is quiet once the line has stayed high for about 1.6 bit periods. That duration is measured in ticks of an 8x oversampling enable.

The raw line enters through a two-flop synchronizer. Every transition of the synchronized line ends the current quiet period: it drops the flag and restarts both measurements. The surrounding receiver supplies a per-bit sample strobe and the oversampling enable. Clock recovery, decoding and framing stay outside this block. The flag is sticky. Once set, it stays high until the line next changes level, whatever further strobes or ticks arrive.

Top module: `rx_idle_detect`

## Requirements
- R1: After reset `idle_o` is 0 and both measurements are cleared: fourteen bit strobes with the line high after reset leave `idle_o` at 0, and a fifteenth sets it.
- R2: A level change on `rx_i` captured at clock edge k clears `idle_o` at edge k+2, and not at edge k+1.
- R3: With `mode_csma_i` = 0 (HDLC-style), `idle_o` rises after the 15th consecutive `bit_stb_i` pulse that samples the synchronized line high. After 14 such pulses it stays 0.
- R4: In HDLC-style mode the ones run restarts from zero when a strobe samples the line low or when the line changes level. After that, 15 fresh one bits are needed again.
- R5: With `mode_csma_i` = 1 (CSMA/CD), `idle_o` rises after 13 `os_tick_i` pulses with the synchronized line continuously high. After 12 pulses it stays 0.
- R6: In CSMA/CD mode the high-time measurement restarts from zero whenever the line is low or changes level.
- R7: In HDLC-style mode `os_tick_i` has no effect on `idle_o`. In CSMA/CD mode `bit_stb_i` has no effect on `idle_o`.
- R8: Once set, `idle_o` stays 1 under further strobes or ticks, and it falls only after a line transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Raw serial receive line, asynchronous to clk_i |
| bit_stb_i | input | 1 | One-cycle pulse at each bit sample point |
| os_tick_i | input | 1 | One-cycle enable at 8x the bit rate |
| mode_csma_i | input | 1 | 0 = HDLC-style ones run, 1 = CSMA/CD high-time |
| idle_o | output | 1 | Receive line idle flag |

## Verification
The hardest state to reach from the ports is a partly filled measurement being restarted. The flag does not show how far a count has advanced, so a restart that fails to happen is invisible until an exact count of further pulses either sets the flag or does not. The stimulus builds a partial run of 10 bits or 10 ticks and breaks it with a zero bit or a short low pulse. It then sends exactly one pulse fewer than the threshold and checks that the flag is still low, followed by the final pulse, which must set it. The table walk drives each stimulus into the wrong mode to show that pulses in that mode are ignored. Directed cases pin down the two-edge clearing latency and the sticky flag.

// File: rtl/rx_idle_pkg.sv
`timescale 1ns/1ps
package rx_idle_pkg;
  typedef enum logic {
    MODE_HDLC = 1'b0,
    MODE_CSMA = 1'b1
  } idle_mode_e;

  // Timeout in tenths of a bit period and oversampling ratio
  localparam int unsigned DEF_RUN_LEN     = 15;
  localparam int unsigned DEF_OS_RATE     = 8;
  localparam int unsigned DEF_IDLE_TENTHS = 16;

  function automatic int unsigned ticks_for(input int unsigned os_rate,
                                            input int unsigned tenths);
    return (os_rate * tenths + 9) / 10;
  endfunction
endpackage

// File: rtl/rx_line_sync.sv
`timescale 1ns/1ps
module rx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic line_o,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], rx_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign line_o = sync_q[STAGES-1];
  assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/ones_run_counter.sv
`timescale 1ns/1ps
module ones_run_counter #(
  parameter int unsigned RUN_LEN = 15,
  localparam int unsigned W = $clog2(RUN_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic edge_i,
  input  logic stb_i,
  output logic full_o
);
  localparam logic [W-1:0] LIMIT = W'(RUN_LEN);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (edge_i) begin
      cnt_d = (stb_i && line_i) ? W'(1) : '0;
    end else if (stb_i) begin
      if (!line_i)             cnt_d = '0;
      else if (cnt_q != LIMIT) cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign full_o = (cnt_q == LIMIT);

  assert_run_bounded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  assert_zero_bit_restarts_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !line_i) |=> (cnt_q == '0));
  assert_edge_restarts_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && !stb_i) |=> (cnt_q == '0));
  assert_one_bit_counts_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && line_i && !edge_i && cnt_q != LIMIT) |=> (cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/high_time_timer.sv
`timescale 1ns/1ps
module high_time_timer #(
  parameter int unsigned LIMIT_TICKS = 13,
  localparam int unsigned W = $clog2(LIMIT_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic edge_i,
  input  logic tick_i,
  output logic full_o
);
  localparam logic [W-1:0] LIMIT = W'(LIMIT_TICKS);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (edge_i || !line_i)              cnt_d = '0;
    else if (tick_i && cnt_q != LIMIT)  cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign full_o = (cnt_q == LIMIT);

  assert_timer_bounded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  assert_low_restarts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_i || edge_i) |=> (cnt_q == '0));
  assert_no_tick_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i && !edge_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rx_idle_detect.sv
`timescale 1ns/1ps
module rx_idle_detect
  import rx_idle_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RUN_LEN     = DEF_RUN_LEN,
  parameter int unsigned OS_RATE     = DEF_OS_RATE,
  parameter int unsigned IDLE_TENTHS = DEF_IDLE_TENTHS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic bit_stb_i,
  input  logic os_tick_i,
  input  logic mode_csma_i,
  output logic idle_o
);
  localparam int unsigned LIMIT_TICKS = ticks_for(OS_RATE, IDLE_TENTHS);

  idle_mode_e mode;
  logic line, line_edge, run_full, time_full, hit;
  logic idle_q, idle_d;

  assign mode = idle_mode_e'(mode_csma_i);

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .rx_i (rx_i),
    .line_o (line), .edge_o (line_edge)
  );

  ones_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i (clk_i), .rst_ni (rst_ni), .line_i (line),
    .edge_i (line_edge), .stb_i (bit_stb_i), .full_o (run_full)
  );

  high_time_timer #(.LIMIT_TICKS(LIMIT_TICKS)) u_time (
    .clk_i (clk_i), .rst_ni (rst_ni), .line_i (line),
    .edge_i (line_edge), .tick_i (os_tick_i), .full_o (time_full)
  );

  always_comb begin
    hit = (mode == MODE_CSMA) ? time_full : run_full;
    if (line_edge) idle_d = 1'b0;
    else if (hit)  idle_d = 1'b1;
    else           idle_d = idle_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idle_q <= 1'b0;
    else         idle_q <= idle_d;
  end

  assign idle_o = idle_q;

  assert_edge_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_edge |=> !idle_o);
  assert_rise_has_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> $past(mode == MODE_CSMA ? time_full : run_full));
  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && !line_edge) |=> idle_o);
endmodule

// File: tb/tb_rx_idle_detect.sv
`timescale 1ns/1ps
module tb_rx_idle_detect;
  logic clk = 1'b0;
  logic rst_n, rx, stb, tick, mode;
  logic idle;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rx_idle_detect dut (
    .clk_i (clk), .rst_ni (rst_n), .rx_i (rx), .bit_stb_i (stb),
    .os_tick_i (tick), .mode_csma_i (mode), .idle_o (idle)
  );

  // {mode, use_tick, count[5:0], expected}
  localparam int NVEC = 10;
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 6'd14, 1'b0},  // R3 one short
    {1'b0, 1'b0, 6'd15, 1'b1},  // R3 threshold
    {1'b0, 1'b0, 6'd20, 1'b1},  // R3 beyond
    {1'b1, 1'b1, 6'd12, 1'b0},  // R5 one short
    {1'b1, 1'b1, 6'd13, 1'b1},  // R5 threshold
    {1'b1, 1'b1, 6'd16, 1'b1},  // R5 beyond
    {1'b0, 1'b1, 6'd30, 1'b0},  // R7 ticks ignored
    {1'b1, 1'b0, 6'd30, 1'b0},  // R7 strobes ignored
    {1'b0, 1'b0, 6'd0,  1'b0},  // R3 nothing
    {1'b1, 1'b1, 6'd0,  1'b0}   // R5 nothing
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic use_tick, input int n);
    for (int p = 0; p < n; p++) begin
      if (use_tick) tick = 1'b1; else stb = 1'b1;
      step(1);
      tick = 1'b0; stb = 1'b0;
      step(1);
    end
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s idle_o actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic line_low_high();
    rx = 1'b0; step(4);
    rx = 1'b1; step(4);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog idle_o actual %b expected finish", idle);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx = 1'b1; stb = 1'b0; tick = 1'b0; mode = 1'b0;
    step(3);
    chk(idle, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    step(4);
    chk(idle, 1'b0, "R1 after release");
    pulse(1'b0, 14);
    step(3);
    chk(idle, 1'b0, "R1 cleared run after reset, 14 bits");
    pulse(1'b0, 1);
    step(3);
    chk(idle, 1'b1, "R1 15th bit after reset");

    for (int i = 0; i < NVEC; i++) begin
      mode = VEC[i][8];
      line_low_high();
      pulse(VEC[i][7], int'(VEC[i][6:1]));
      step(3);
      chk(idle, VEC[i][0], $sformatf("R3/R5/R7 vector %0d", i));
    end

    // R2 latency and R8 stickiness
    mode = 1'b0;
    line_low_high();
    pulse(1'b0, 15);
    step(3);
    chk(idle, 1'b1, "R8 set");
    pulse(1'b0, 5);
    pulse(1'b1, 5);
    step(2);
    chk(idle, 1'b1, "R8 stays set under strobes and ticks");
    rx = 1'b0;            // captured at next edge k
    @(posedge clk); #1;   // edge k
    @(posedge clk); #1;   // edge k+1
    chk(idle, 1'b1, "R2 not cleared at k+1");
    @(posedge clk); #1;   // edge k+2
    chk(idle, 1'b0, "R2 cleared at k+2");
    step(2);

    // R4 zero bit restarts run
    mode = 1'b0;
    line_low_high();
    pulse(1'b0, 10);
    rx = 1'b0; step(4);
    pulse(1'b0, 1);
    rx = 1'b1; step(4);
    pulse(1'b0, 14);
    step(3);
    chk(idle, 1'b0, "R4 run restarted, 14 bits");
    pulse(1'b0, 1);
    step(3);
    chk(idle, 1'b1, "R4 15th fresh bit");

    // R4 edge alone restarts run (short low pulse, no strobe while low)
    line_low_high();
    pulse(1'b0, 10);
    rx = 1'b0; step(1); rx = 1'b1; step(4);
    pulse(1'b0, 14);
    step(3);
    chk(idle, 1'b0, "R4 edge restarted run");

    // R6 high time restarted by low pulse
    mode = 1'b1;
    line_low_high();
    pulse(1'b1, 10);
    rx = 1'b0; step(1); rx = 1'b1; step(4);
    pulse(1'b1, 12);
    step(3);
    chk(idle, 1'b0, "R6 timer restarted, 12 ticks");
    pulse(1'b1, 1);
    step(3);
    chk(idle, 1'b1, "R6 13th fresh tick");

    // R6 ticks while low do not accumulate
    line_low_high();
    rx = 1'b0; step(4);
    pulse(1'b1, 20);
    rx = 1'b1; step(4);
    pulse(1'b1, 12);
    step(3);
    chk(idle, 1'b0, "R6 low-time ticks discarded");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule